// File: doc/BRIEF.md
# Multiplexed Bus Target Port

This block is the target side of a 32-bit shared bus that carries the address and the data on the same wires, with active-low control lines. An initiator opens a transaction by pulling its frame line low for one cycle with the address on the data wires and a command on the command/byte-enable wires. The block captures both, decodes them one cycle later, and claims the transaction only if the command is a memory read or memory write and the address falls inside its aligned window. The window starts at a base address given on an input port.

Once it has claimed a transaction, the block moves 32-bit words between the bus and a small internal register array, one word per data phase. A phase completes only on a clock edge where the initiator-ready and target-ready lines are both low. Writes honour the byte-lane enables. A burst walks the array linearly. When the burst reaches the last word of the window, the block raises the stop request together with target-ready, so the initiator ends the transfer there.

At the end of every claimed transaction, the block drives its select, ready and stop lines high for one cycle and only then releases them. Tri-state control is modelled by separate output-enable signals.

Top module: `pbus_target`

## Requirements
- R1: While the synchronous reset is low and in the first cycle after it, every output enable (`ad_oe`, `devsel_oe`, `trdy_oe`, `stop_oe`) is 0 and `devsel_n`, `trdy_n`, `stop_n` are 1.
- R2: An address phase is the first cycle with `frame_n` low after a cycle with `frame_n` high. The block claims only memory read (command 4'b0110) and memory write (command 4'b0111) with an address whose bits above the window inside (`ad_in[31:6]` by default) equal the same bits of `win_base`. Any other command or address leaves `devsel_oe` and `trdy_oe` at 0 and the array unchanged.
- R3: On a claimed transaction, `devsel_n` goes low in the second cycle after the address phase and never in the first. It stays low until the final data phase completes.
- R4: `trdy_n` is low only while `devsel_n` is low. A data phase completes only on an edge where `irdy_n` and `trdy_n` are both low. Holding `irdy_n` high inserts a wait state that leaves the word index and the array unchanged.
- R5: On a write phase, byte k of the addressed word (bits 8k+7..8k) is written only when `cbe_n[k]` is 0. Masked lanes keep their old value.
- R6: On a claimed read, `ad_oe` is 1 exactly in the cycles where `trdy_n` is low, and `ad_out` then carries the stored word at the current index. On writes and outside data phases, `ad_oe` is 0.
- R7: The starting word index is address bits [5:2] (by default). It advances by one after each completed data phase, so a burst moves consecutive words.
- R8: While the current index is the last word of the window, `stop_n` is low together with `trdy_n`. A burst that runs into the window end therefore transfers up to and including that word and no further.
- R9: In the cycle after the final data phase, `devsel_n`, `trdy_n` and `stop_n` are driven high with their enables at 1. In the cycle after that, all enables are 0.
- R10: A new address phase that arrives in the cycle where the lines are being driven high (back-to-back) is captured and served like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| win_base | input | 32 | Base address of the claimed window; bits below the window size are ignored |
| frame_n | input | 1 | Initiator frame line, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_in | input | 32 | Sampled address/data wires |
| ad_out | output | 32 | Read data driven onto the address/data wires |
| ad_oe | output | 1 | Output enable for `ad_out` |
| devsel_n | output | 1 | Device-select claim, active low |
| devsel_oe | output | 1 | Output enable for `devsel_n` |
| trdy_n | output | 1 | Target ready, active low |
| trdy_oe | output | 1 | Output enable for `trdy_n` |
| stop_n | output | 1 | Stop request (disconnect), active low |
| stop_oe | output | 1 | Output enable for `stop_n` |

## Verification
The embedded assertions watch the line discipline on every cycle. Target-ready and stop never appear without the device select. No enable drops while its line is low, and each enable drops only after one cycle of the line driven high. The device select always falls exactly two cycles after a frame falling edge, and stop together with target-ready occurs only on the last window word. Whether the right bytes landed in the right words, whether read data matches what was written, how long a burst runs before disconnect, and whether unclaimed commands leave the array untouched can only be shown by the bench's transaction scenarios against its own memory model.

// File: rtl/pbt_pkg.sv
// Package: shared state encoding and command codes for the bus target.
// Assumes the active-low command codes of the multiplexed bus.
package pbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for an address phase
        ST_DECODE,  // captured address under decode
        ST_DATA,    // claimed, target ready asserted
        ST_HOLD,    // disconnect issued, waiting for frame to end
        ST_TURN     // lines driven high for one cycle before release
    } pbt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pbt_decode.sv
// Module: address/command decoder.
// Decides from a captured address phase whether the transaction hits the
// aligned window and gives the starting word index. Purely combinational;
// assumes WORDS is a power of two, at least 2.
module pbt_decode #(
    parameter int DW    = 32,
    parameter int WORDS = 16
) (
    input  logic [DW-1:0]            addr,
    input  logic [3:0]               cmd,
    input  logic [DW-1:0]            base,
    output logic                     hit,
    output logic                     is_read,
    output logic [$clog2(WORDS)-1:0] start_idx
);
    import pbt_pkg::*;

    localparam int IDX_W = $clog2(WORDS);
    localparam int BW    = IDX_W + 2;
    localparam logic [DW-1:0] HI_MASK = {DW{1'b1}} << BW;

    logic in_window;
    logic cmd_ok;

    // Window and command match for the captured address phase.
    always_comb begin
        in_window = (((addr ^ base) & HI_MASK) == '0);
        cmd_ok    = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        hit       = in_window && cmd_ok;
        is_read   = (cmd == CMD_MEM_RD);
        start_idx = addr[BW-1:2];
    end

endmodule

// File: rtl/pbt_regfile.sv
// Module: byte-maskable register array.
// Holds WORDS words of DW bits, cleared at reset. One port: combinational
// read of the indexed word, and a write that updates only the lanes whose
// active-low enable is 0.
module pbt_regfile #(
    parameter int DW    = 32,
    parameter int WORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DW/8-1:0]          be_n,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    localparam int LANES = DW / 8;

    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] lane_mask;

    // Expand each active-low lane enable to a byte-wide bit mask.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*8 +: 8] = {8{~be_n[l]}};
    end

    // Clear the array at reset; merge enabled lanes on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= (mem_q[idx] & ~lane_mask) | (wdata & lane_mask);
        end
    end

    // Read port: current word.
    assign rdata = mem_q[idx];

endmodule

// File: rtl/pbus_target.sv
// Module: target port of a multiplexed address/data bus.
// Captures address and command on a frame falling edge, decodes one cycle
// later, claims with medium select timing, moves one word per phase when
// both ready lines are low, disconnects at the window end, and drives its
// lines high for one cycle before releasing them.
// Assumes the initiator follows the bus protocol (frame high on the last
// phase, ready held until the phase completes).
module pbus_target #(
    parameter int DW    = 32,
    parameter int WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] win_base,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic [3:0]    cbe_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          devsel_n,
    output logic          devsel_oe,
    output logic          trdy_n,
    output logic          trdy_oe,
    output logic          stop_n,
    output logic          stop_oe
);
    import pbt_pkg::*;

    localparam int IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    pbt_state_e       state_q;
    logic             frame_q;
    logic [DW-1:0]    addr_q;
    logic [3:0]       cmd_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit;
    logic             is_read;
    logic [IDX_W-1:0] start_idx;
    logic             addr_phase;
    logic             xfer;
    logic             wr_en;
    logic [DW-1:0]    rd_word;

    pbt_decode #(.DW(DW), .WORDS(WORDS)) decode_i (
        .addr      (addr_q),
        .cmd       (cmd_q),
        .base      (win_base),
        .hit       (hit),
        .is_read   (is_read),
        .start_idx (start_idx)
    );

    pbt_regfile #(.DW(DW), .WORDS(WORDS)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .idx   (idx_q),
        .be_n  (cbe_n[DW/8-1:0]),
        .wdata (ad_in),
        .rdata (rd_word)
    );

    // Address phase: frame seen low after it was high at the previous edge.
    assign addr_phase = frame_q && !frame_n;
    // A data phase completes when the initiator is ready while we are.
    assign xfer  = (state_q == ST_DATA) && !irdy_n;
    assign wr_en = xfer && !is_read;

    // Transaction sequencing and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b1;
            addr_q  <= '0;
            cmd_q   <= '0;
            idx_q   <= '0;
        end else begin
            frame_q <= frame_n;
            case (state_q)
                ST_IDLE, ST_TURN: begin
                    if (addr_phase) begin
                        addr_q  <= ad_in;
                        cmd_q   <= cbe_n;
                        state_q <= ST_DECODE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_DECODE: begin
                    if (hit) begin
                        idx_q   <= start_idx;
                        state_q <= ST_DATA;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (frame_n) begin
                            state_q <= ST_TURN;
                        end else if (idx_q == LAST_IDX) begin
                            state_q <= ST_HOLD;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (frame_n) begin
                        state_q <= ST_TURN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus line drive from the current state.
    always_comb begin
        devsel_oe = (state_q == ST_DATA) || (state_q == ST_HOLD) || (state_q == ST_TURN);
        trdy_oe   = devsel_oe;
        stop_oe   = devsel_oe;
        devsel_n  = !((state_q == ST_DATA) || (state_q == ST_HOLD));
        trdy_n    = !(state_q == ST_DATA);
        stop_n    = !(((state_q == ST_DATA) && (idx_q == LAST_IDX)) || (state_q == ST_HOLD));
        ad_oe     = (state_q == ST_DATA) && is_read;
        ad_out    = rd_word;
    end

    AST_MEDIUM_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(frame_n, 3))) else $error("medium select timing"); // R3
    AST_TRDY_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n) else $error("ready without select"); // R4
    AST_AD_WITH_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !trdy_n) else $error("data driven outside phase"); // R6
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !trdy_n) |-> (idx_q == LAST_IDX)) else $error("early disconnect"); // R8
    AST_DEVSEL_NO_FLOAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe && !devsel_n) |=> devsel_oe) else $error("select released low"); // R9
    AST_STOP_NO_FLOAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_oe && !stop_n) |=> stop_oe) else $error("stop released low"); // R9
    AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_oe) |-> ($past(trdy_n) && $past(devsel_n) && $past(stop_n))) else $error("release without high cycle"); // R9

endmodule

// File: tb/pbus_target_tb_top.sv
// Bench: acts as bus initiator, keeps its own word memory model and checks
// every bus-visible output cycle by cycle against protocol expectations.
module pbus_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 16;
    localparam logic [31:0] BASE = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win_base = BASE;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    logic [31:0] ref_mem [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_target #(.DW(32), .WORDS(WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .win_base(win_base), .frame_n(frame_n),
        .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .devsel_n(devsel_n), .devsel_oe(devsel_oe),
        .trdy_n(trdy_n), .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Lines released and high.
    task automatic chk_released(input string req);
        logic [6:0] act;
        act = {ad_oe, devsel_oe, trdy_oe, stop_oe, devsel_n, trdy_n, stop_n};
        chk(act == 7'b0000111, req, "released lines {oe x4,devsel,trdy,stop}", 32'(act), 32'h07);
    endtask

    // One idle cycle on the bus.
    task automatic idle();
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        @(negedge clk);
        chk_released("R9");
    endtask

    // One transaction, started at a negedge; returns words moved.
    task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                       input logic [31:0] wd0, input logic [3:0] be,
                       input int wait_at, output int done);
        bit claim;
        bit rd;
        bit waited;
        bit last;
        int idx;
        int p;
        logic [31:0] wd;
        claim = (addr[31:6] == BASE[31:6]) && (cmd == 4'b0110 || cmd == 4'b0111);
        rd = (cmd == 4'b0110);
        done = 0;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        chk(!devsel_oe && devsel_n, "R3", "no claim in first cycle", {31'b0, devsel_oe}, 32'h0);
        ad_in = '0; cbe_n = be;
        if (!claim) begin
            frame_n = 1'b1; irdy_n = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!devsel_oe && !trdy_oe, "R2", "unclaimed cycle enables", {30'b0, devsel_oe, trdy_oe}, 32'h0);
                irdy_n = 1'b1;
            end
            return;
        end
        frame_n = 1'b0; irdy_n = 1'b1;
        idx = int'(addr[5:2]);
        p = 0;
        waited = 0;
        while (p < n) begin
            @(negedge clk);
            chk(devsel_oe && !devsel_n, "R3", "select held low", {31'b0, devsel_n}, 32'h0);
            chk(trdy_oe && !trdy_n, "R4", "target ready in phase", {31'b0, trdy_n}, 32'h0);
            chk(stop_n == (idx != WORDS-1), "R8", "stop at window end", {31'b0, stop_n}, {31'b0, idx != WORDS-1});
            if (rd) begin
                chk(ad_oe == 1'b1, "R6", "read drive enable", {31'b0, ad_oe}, 32'h1);
                chk(ad_out == ref_mem[idx], "R7", "read word", ad_out, ref_mem[idx]);
            end else begin
                chk(ad_oe == 1'b0, "R6", "no drive on write", {31'b0, ad_oe}, 32'h0);
            end
            if (p == wait_at && !waited) begin
                waited = 1;
                irdy_n = 1'b1; frame_n = 1'b0;
                continue;
            end
            last = (p == n-1) || (idx == WORDS-1);
            wd = wd0 + 32'(p) * 32'h0101_0101;
            irdy_n = 1'b0; frame_n = last; ad_in = wd; cbe_n = be;
            if (!rd) begin
                for (int b = 0; b < 4; b++) begin
                    if (!be[b]) ref_mem[idx][b*8 +: 8] = wd[b*8 +: 8];
                end
            end
            p++;
            if (last) break;
            idx++;
        end
        done = p;
        @(negedge clk);
        chk(devsel_oe && trdy_oe && stop_oe && devsel_n && trdy_n && stop_n && !ad_oe,
            "R9", "high drive cycle", {25'b0, ad_oe, devsel_oe, trdy_oe, stop_oe, devsel_n, trdy_n, stop_n}, 32'h3F);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int d;
        for (int w = 0; w < WORDS; w++) ref_mem[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_released("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_released("R1");

        // R5 R6 single write and read back
        txn(BASE + 32'h08, 4'b0111, 1, 32'h1122_3344, 4'b0000, -1, d); idle();
        txn(BASE + 32'h08, 4'b0110, 1, 32'h0, 4'b0000, -1, d); idle();
        // R4 R7 bursts with initiator wait states
        txn(BASE + 32'h10, 4'b0111, 4, 32'hA0B0_C0D0, 4'b0000, 1, d); idle();
        chk(d == 4, "R7", "write burst length", 32'(d), 32'd4);
        txn(BASE + 32'h10, 4'b0110, 4, 32'h0, 4'b0000, 2, d); idle();
        // R5 byte-masked write: lanes 0 and 2 only
        txn(BASE + 32'h08, 4'b0111, 1, 32'hAABB_CCDD, 4'b1010, -1, d); idle();
        txn(BASE + 32'h08, 4'b0110, 1, 32'h0, 4'b0000, -1, d); idle();
        chk(ref_mem[2] == 32'h11BB_33DD, "R5", "model merge", ref_mem[2], 32'h11BB_33DD);
        // R2 outside window, then other command inside window
        txn(BASE + 32'h1000, 4'b0111, 1, 32'hDEAD_BEEF, 4'b0000, -1, d); idle();
        txn(BASE + 32'h08, 4'b0011, 1, 32'hDEAD_BEEF, 4'b0000, -1, d); idle();
        txn(BASE + 32'h08, 4'b0110, 1, 32'h0, 4'b0000, -1, d); idle();
        // R8 disconnect at window end
        txn(BASE + 32'h34, 4'b0111, 5, 32'h5000_0001, 4'b0000, -1, d); idle();
        chk(d == 3, "R8", "write burst cut at window end", 32'(d), 32'd3);
        txn(BASE + 32'h30, 4'b0110, 6, 32'h0, 4'b0000, -1, d); idle();
        chk(d == 4, "R8", "read burst cut at window end", 32'(d), 32'd4);
        // R10 back-to-back: read issued during the high drive cycle
        txn(BASE + 32'h00, 4'b0111, 1, 32'h0F0E_0D0C, 4'b0000, -1, d);
        txn(BASE + 32'h00, 4'b0110, 1, 32'h0, 4'b0000, -1, d);
        chk(d == 1, "R10", "back-to-back read served", 32'(d), 32'd1);
        idle();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule